// File: doc/BRIEF.md
# Processor Bus Dummy-Cycle Classifier

This block is a passive observer placed next to the bus of an 8-bit microprocessor. On every clock it samples the opcode-fetch strobe, the read/write line, the upper byte of the address and the data byte. From these it works out how far the processor has got into the current instruction. For each bus cycle it then reports whether the access is genuine or a throwaway internal cycle. A debug checker that traps reads of uninitialised memory uses this verdict to skip the throwaway cycles.

The tracker locks onto the instruction stream each time the fetch strobe is seen. It then follows a fixed per-opcode cycle script for five instruction kinds: the software break, the two return instructions, the subroutine call and the conditional branches. Any other opcode puts the tracker in pass-through, where every cycle counts as real until the next fetch.

For the branch cycle that only exists when the target lies on another page, the verdict is given one cycle late on a separate pulse. If the observed bus does not match the script, the block raises a one-cycle error pulse and stops trusting the script. This happens for a fetch strobe in the wrong place, a transfer in the wrong direction, or a stack access outside the stack page.

Top module: `bus_cycle_classifier`

## Requirements
- R1: From reset until the first cycle with `sync_i` high, `locked_o`, `real_o`, `dummy_o`, `seq_err_o` and `late_dummy_o` are all 0.
- R2: A cycle with `sync_i` high is an opcode fetch. In that cycle `locked_o`=1, `real_o`=1 and `dummy_o`=0, and the data byte is taken as the new opcode.
- R3: Opcode 0x00 (break). Counting the fetch as step 0: step 1 is a dummy read; steps 2–4 are real stack writes (`rw_i`=0, `addr_hi_i`=0x01); steps 5 and 6 are real reads. The next fetch is expected at step 7.
- R4: Opcode 0x40 (return from interrupt): step 1 is a dummy read; step 2 is a dummy stack read; steps 3–5 are real stack reads. The next fetch is expected at step 6.
- R5: Opcode 0x60 (return from subroutine): step 1 is a dummy read; step 2 is a dummy stack read; steps 3 and 4 are real stack reads; step 5 is a dummy read. The next fetch is expected at step 6.
- R6: Opcode 0x20 (subroutine call): step 1 is a real read; step 2 is a dummy cycle at the stack page with either direction; steps 3 and 4 are real stack writes; step 5 is a real read. The next fetch is expected at step 6.
- R7: An opcode whose low nibble is 0 and whose high nibble is odd is a branch. Step 1 is a real read. Step 2 without `sync_i` is a dummy cycle of either direction. A fetch at step 2, 3 or 4 is expected.
- R8: In a branch, step 3 without `sync_i` reports neither `real_o` nor `dummy_o`, and `late_dummy_o` is 1 in the following cycle. `late_dummy_o` is 0 in every other cycle.
- R9: After any opcode outside R3–R7, every cycle without `sync_i` is reported real, with no error, until the next fetch.
- R10: A fetch at a step where the script does not expect one sets `seq_err_o`=1 for that cycle only. That cycle is reported real, and the new opcode is tracked from it.
- R11: In a scripted step with a fixed direction, a wrong `rw_i` (1 = read) sets `seq_err_o`=1 and the cycle is reported real. The same happens in a scripted stack step whose `addr_hi_i` is not 0x01. In both cases the tracker falls to pass-through as in R9.
- R12: A non-fetch cycle at the step where the script expected a fetch is reported real without error, and the tracker falls to pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Opcode-fetch strobe of the processor |
| rw_i | input | 1 | Transfer direction, 1 = read, 0 = write |
| addr_hi_i | input | 8 | Upper byte of the address bus |
| data_i | input | 8 | Data bus byte |
| locked_o | output | 1 | Tracker has seen at least one fetch since reset |
| real_o | output | 1 | Current cycle is a genuine access |
| dummy_o | output | 1 | Current cycle is a throwaway internal cycle |
| seq_err_o | output | 1 | Current cycle contradicts the expected script |
| late_dummy_o | output | 1 | Previous cycle (branch page-cross step) was a dummy |

## Verification
The assertions watch properties that hold cycle by cycle on any bus traffic:
- R1: the outputs stay silent before lock.
- R2 and R10: a fetch is always real, and an error cycle is always real.
- R5: the byte after a return-from-subroutine fetch is never called real.
- R8: each pending verdict is followed by exactly the late pulse.
- R9: pass-through persists until a fetch.

Only the bench scenarios can show that each opcode's script puts dummy and real cycles at the right step numbers. The same holds for early fetches, overruns and corrupted direction or page being classified exactly as R10–R12 state. For these the bench runs random instruction streams mixed with truncated, overrun and corrupted scripts.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    localparam int STEP_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_BRK = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_JSR = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_RTI = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_RTS = 8'h60;

    typedef enum logic [2:0] {
        OC_BRK, OC_RTI, OC_RTS, OC_JSR, OC_BRANCH, OC_OTHER
    } op_class_e;

    typedef enum logic [1:0] {
        TM_UNLOCKED, TM_SCRIPT, TM_PASS
    } track_mode_e;

    typedef enum logic [1:0] {
        BD_ANY, BD_READ, BD_WRITE
    } bus_dir_e;

    typedef struct packed {
        logic     dummy;
        logic     pending;
        logic     on_stack;
        bus_dir_e dir;
    } step_spec_t;

    typedef struct packed {
        track_mode_e       mode;
        op_class_e         cls;
        logic [STEP_W-1:0] step;
    } track_state_t;

    // Step at which the next opcode fetch is due (the fetch itself is step 0).
    function automatic logic [STEP_W-1:0] script_end(op_class_e c);
        case (c)
            OC_BRK:    return STEP_W'(7);
            OC_RTI,
            OC_RTS,
            OC_JSR:    return STEP_W'(6);
            OC_BRANCH: return STEP_W'(4);
            default:   return STEP_W'(0);
        endcase
    endfunction

    function automatic logic sync_allowed(op_class_e c, logic [STEP_W-1:0] s);
        return (s == script_end(c)) ||
               (c == OC_BRANCH && (s == STEP_W'(2) || s == STEP_W'(3)));
    endfunction

    function automatic step_spec_t mk_spec(logic d, logic p, logic stk, bus_dir_e dir);
        step_spec_t r;
        r.dummy    = d;
        r.pending  = p;
        r.on_stack = stk;
        r.dir      = dir;
        return r;
    endfunction

    // Cycle script: what each step after the fetch is supposed to look like.
    function automatic step_spec_t step_spec(op_class_e c, logic [STEP_W-1:0] s);
        step_spec_t r;
        r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
        case (c)
            OC_BRK: begin
                case (s)
                    3'd1:             r = mk_spec(1'b1, 1'b0, 1'b0, BD_READ);
                    3'd2, 3'd3, 3'd4: r = mk_spec(1'b0, 1'b0, 1'b1, BD_WRITE);
                    3'd5, 3'd6:       r = mk_spec(1'b0, 1'b0, 1'b0, BD_READ);
                    default:          r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
                endcase
            end
            OC_RTI: begin
                case (s)
                    3'd1:             r = mk_spec(1'b1, 1'b0, 1'b0, BD_READ);
                    3'd2:             r = mk_spec(1'b1, 1'b0, 1'b1, BD_READ);
                    3'd3, 3'd4, 3'd5: r = mk_spec(1'b0, 1'b0, 1'b1, BD_READ);
                    default:          r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
                endcase
            end
            OC_RTS: begin
                case (s)
                    3'd1:       r = mk_spec(1'b1, 1'b0, 1'b0, BD_READ);
                    3'd2:       r = mk_spec(1'b1, 1'b0, 1'b1, BD_READ);
                    3'd3, 3'd4: r = mk_spec(1'b0, 1'b0, 1'b1, BD_READ);
                    3'd5:       r = mk_spec(1'b1, 1'b0, 1'b0, BD_READ);
                    default:    r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
                endcase
            end
            OC_JSR: begin
                case (s)
                    3'd1:       r = mk_spec(1'b0, 1'b0, 1'b0, BD_READ);
                    3'd2:       r = mk_spec(1'b1, 1'b0, 1'b1, BD_ANY);
                    3'd3, 3'd4: r = mk_spec(1'b0, 1'b0, 1'b1, BD_WRITE);
                    3'd5:       r = mk_spec(1'b0, 1'b0, 1'b0, BD_READ);
                    default:    r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
                endcase
            end
            OC_BRANCH: begin
                case (s)
                    3'd1:    r = mk_spec(1'b0, 1'b0, 1'b0, BD_READ);
                    3'd2:    r = mk_spec(1'b1, 1'b0, 1'b0, BD_ANY);
                    3'd3:    r = mk_spec(1'b0, 1'b1, 1'b0, BD_ANY);
                    default: r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
                endcase
            end
            default: r = mk_spec(1'b0, 1'b0, 1'b0, BD_ANY);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/busmon_opdec.sv
module busmon_opdec
    import busmon_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_class_e         cls
);
    localparam int NIB_W = BYTE_W / 2;

    logic is_branch;
    assign is_branch = (opcode[NIB_W-1:0] == '0) && opcode[NIB_W];

    always_comb begin
        if (is_branch)             cls = OC_BRANCH;
        else if (opcode == OPC_BRK) cls = OC_BRK;
        else if (opcode == OPC_RTI) cls = OC_RTI;
        else if (opcode == OPC_RTS) cls = OC_RTS;
        else if (opcode == OPC_JSR) cls = OC_JSR;
        else                        cls = OC_OTHER;
    end
endmodule

// File: rtl/busmon_tracker.sv
module busmon_tracker
    import busmon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sync,
    input  logic         abort,
    input  op_class_e    new_cls,
    output track_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode <= TM_UNLOCKED;
            st.cls  <= OC_OTHER;
            st.step <= '0;
        end else if (sync) begin
            st.mode <= (new_cls == OC_OTHER) ? TM_PASS : TM_SCRIPT;
            st.cls  <= new_cls;
            st.step <= STEP_W'(1);
        end else if (st.mode == TM_SCRIPT) begin
            if (abort || st.step == script_end(st.cls)) begin
                st.mode <= TM_PASS;
            end else begin
                st.step <= st.step + STEP_W'(1);
            end
        end
    end

    // R9: pass-through is left only through a fetch
    assert_pass_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (st.mode == TM_PASS && !sync) |=> (st.mode == TM_PASS));

    // R2: a fetch always restarts the script count
    assert_fetch_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        sync |=> (st.step == STEP_W'(1) && st.mode != TM_UNLOCKED));
endmodule

// File: rtl/busmon_verdict.sv
module busmon_verdict
    import busmon_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  track_state_t      st,
    input  logic              sync,
    input  logic              rw,
    input  logic [BYTE_W-1:0] addr_hi,
    output logic              locked,
    output logic              is_real,
    output logic              is_dummy,
    output logic              seq_err,
    output logic              abort,
    output logic              pending
);
    step_spec_t spec;
    logic       at_end;
    logic       dir_bad;
    logic       page_bad;

    assign spec     = step_spec(st.cls, st.step);
    assign at_end   = (st.step == script_end(st.cls));
    assign dir_bad  = (spec.dir == BD_READ && !rw) || (spec.dir == BD_WRITE && rw);
    assign page_bad = spec.on_stack && (addr_hi != STACK_PAGE);
    assign locked   = (st.mode != TM_UNLOCKED) || sync;

    always_comb begin
        is_real  = 1'b0;
        is_dummy = 1'b0;
        seq_err  = 1'b0;
        abort    = 1'b0;
        pending  = 1'b0;
        if (sync) begin
            is_real = 1'b1;
            seq_err = (st.mode == TM_SCRIPT) && !sync_allowed(st.cls, st.step);
        end else begin
            case (st.mode)
                TM_PASS: is_real = 1'b1;
                TM_SCRIPT: begin
                    if (at_end) begin
                        is_real = 1'b1;
                    end else if (dir_bad || page_bad) begin
                        is_real = 1'b1;
                        seq_err = 1'b1;
                        abort   = 1'b1;
                    end else if (spec.pending) begin
                        pending = 1'b1;
                    end else if (spec.dummy) begin
                        is_dummy = 1'b1;
                    end else begin
                        is_real = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10 / R11: an error cycle is never called dummy
    assert_error_is_real_R10: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (is_real && !is_dummy && !pending));
endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
    import busmon_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       rw_i,
    input  logic [7:0] addr_hi_i,
    input  logic [7:0] data_i,
    output logic       locked_o,
    output logic       real_o,
    output logic       dummy_o,
    output logic       seq_err_o,
    output logic       late_dummy_o
);
    op_class_e    dec_cls;
    track_state_t st;
    logic         abort;
    logic         pending;
    logic         late_q;

    busmon_opdec u_opdec (
        .opcode (data_i),
        .cls    (dec_cls)
    );

    busmon_tracker u_tracker (
        .clk     (clk),
        .rst     (rst),
        .sync    (sync_i),
        .abort   (abort),
        .new_cls (dec_cls),
        .st      (st)
    );

    busmon_verdict #(.STACK_PAGE(STACK_PAGE)) u_verdict (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .sync     (sync_i),
        .rw       (rw_i),
        .addr_hi  (addr_hi_i),
        .locked   (locked_o),
        .is_real  (real_o),
        .is_dummy (dummy_o),
        .seq_err  (seq_err_o),
        .abort    (abort),
        .pending  (pending)
    );

    // Page-cross branch step: verdict known only once that cycle has ended.
    always_ff @(posedge clk) begin
        if (rst) late_q <= 1'b0;
        else     late_q <= pending;
    end
    assign late_dummy_o = late_q;

    assert_unlocked_silent_R1: assert property (@(posedge clk) disable iff (rst)
        !locked_o |-> (!real_o && !dummy_o && !seq_err_o));

    assert_fetch_real_R2: assert property (@(posedge clk) disable iff (rst)
        sync_i |-> (real_o && !dummy_o && locked_o));

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        !(real_o && dummy_o));

    assert_rts_discard_R5: assert property (@(posedge clk) disable iff (rst)
        (sync_i && data_i == OPC_RTS) |=> (sync_i || dummy_o || seq_err_o));

    assert_late_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !real_o && !dummy_o) |=> late_dummy_o);

    assert_late_cause_R8: assert property (@(posedge clk) disable iff (rst)
        late_dummy_o |-> $past(locked_o && !real_o && !dummy_o));

    assert_abort_passes_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_err_o && !sync_i) |=> (real_o || sync_i));
endmodule

// File: tb/bus_cycle_classifier_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_classifier_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_i = 1'b0;
    logic       rw_i = 1'b1;
    logic [7:0] addr_hi_i = 8'h00;
    logic [7:0] data_i = 8'h00;
    logic       locked_o, real_o, dummy_o, seq_err_o, late_dummy_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_cycle_classifier dut_i (
        .clk(clk), .rst(rst), .sync_i(sync_i), .rw_i(rw_i),
        .addr_hi_i(addr_hi_i), .data_i(data_i),
        .locked_o(locked_o), .real_o(real_o), .dummy_o(dummy_o),
        .seq_err_o(seq_err_o), .late_dummy_o(late_dummy_o)
    );

    // Bench model state: 0 unlocked, 1 scripted, 2 pass-through
    int    m_mode = 0;
    string m_scr = "";
    int    m_step = 0;
    bit    m_late = 1'b0;

    // Step letters: O fetch, d dummy read, D dummy stack read, x dummy stack any,
    // W real stack write, S real stack read, R/r real read, b dummy any, p pending
    function automatic string script_of(logic [7:0] op);
        if (op[3:0] == 4'h0 && op[4]) return "Orbp";
        case (op)
            8'h00:   return "OdWWWRR";
            8'h40:   return "OdDSSS";
            8'h60:   return "OdDSSd";
            8'h20:   return "OrxWWR";
            default: return "";
        endcase
    endfunction

    function automatic string req_of(string s);
        if (s == "OdWWWRR") return "R3";
        if (s == "OdDSSS")  return "R4";
        if (s == "OdDSSd")  return "R5";
        if (s == "OrxWWR")  return "R6";
        return "R7";
    endfunction

    function automatic bit is_stack(byte c);
        return c == "W" || c == "S" || c == "D" || c == "x";
    endfunction

    function automatic bit needs_read(byte c);
        return c == "d" || c == "D" || c == "S" || c == "R" || c == "r";
    endfunction

    function automatic bit is_dummy_ch(byte c);
        return c == "d" || c == "D" || c == "x" || c == "b";
    endfunction

    task automatic cycle(bit s, bit rw, logic [7:0] ahi, logic [7:0] d);
        bit e_lock, e_real, e_dum, e_err, e_late, nxt_late;
        string tag;
        @(negedge clk);
        sync_i = s; rw_i = rw; addr_hi_i = ahi; data_i = d;
        #1;
        e_lock = 0; e_real = 0; e_dum = 0; e_err = 0; e_late = m_late; nxt_late = 0;
        tag = "R1";
        if (s) begin
            e_lock = 1; e_real = 1; tag = "R2";
            if (m_mode == 1 && !(m_step == m_scr.len() ||
                (m_scr == "Orbp" && (m_step == 2 || m_step == 3)))) begin
                e_err = 1; tag = "R10";
            end
            m_scr  = script_of(d);
            m_mode = (m_scr.len() == 0) ? 2 : 1;
            m_step = 1;
        end else if (m_mode == 2) begin
            e_lock = 1; e_real = 1; tag = "R9";
        end else if (m_mode == 1) begin
            e_lock = 1;
            if (m_step == m_scr.len()) begin
                e_real = 1; tag = "R12"; m_mode = 2;
            end else begin
                byte c;
                bit  bad;
                c = m_scr[m_step];
                bad = (c == "W" && rw) || (needs_read(c) && !rw) ||
                      (is_stack(c) && ahi != 8'h01);
                tag = req_of(m_scr);
                if (bad) begin
                    e_real = 1; e_err = 1; tag = "R11"; m_mode = 2;
                end else if (c == "p") begin
                    nxt_late = 1; tag = "R8";
                end else if (is_dummy_ch(c)) begin
                    e_dum = 1;
                end else begin
                    e_real = 1;
                end
                m_step++;
            end
        end
        if (e_late) tag = "R8";
        m_late = nxt_late;
        checks++;
        if ({locked_o, real_o, dummy_o, seq_err_o, late_dummy_o} !==
            {e_lock, e_real, e_dum, e_err, e_late}) begin
            errors++;
            $display("FAIL %s: lock/real/dummy/err/late got %b%b%b%b%b expected %b%b%b%b%b",
                     tag, locked_o, real_o, dummy_o, seq_err_o, late_dummy_o,
                     e_lock, e_real, e_dum, e_err, e_late);
        end
    endtask

    // Emit an instruction: fetch plus (ncyc-1) following cycles; corrupt one step if asked.
    task automatic emit(logic [7:0] op, int ncyc, int corrupt_at);
        string scr;
        scr = script_of(op);
        cycle(1'b1, 1'b1, 8'($urandom), op);
        for (int k = 1; k < ncyc; k++) begin
            bit rw;
            logic [7:0] ahi;
            if (k < scr.len()) begin
                byte c;
                c   = scr[k];
                rw  = (c == "W") ? 1'b0 : (needs_read(c) ? 1'b1 : 1'(($urandom)));
                ahi = is_stack(c) ? 8'h01 : 8'($urandom);
            end else begin
                rw  = 1'($urandom);
                ahi = 8'($urandom);
            end
            if (k == corrupt_at) begin
                rw  = ~rw;
                ahi = 8'h02;
            end
            cycle(1'b0, rw, ahi, 8'($urandom));
        end
    endtask

    function automatic logic [7:0] pick_other();
        logic [7:0] v;
        v = 8'($urandom);
        while (script_of(v).len() != 0) v = 8'($urandom);
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle bus before the first fetch
        repeat (3) cycle(1'b0, 1'b1, 8'h01, 8'h00);
        // Directed scripts: R3 R4 R5 R6
        emit(8'h00, 7, -1);
        emit(8'h40, 6, -1);
        emit(8'h60, 6, -1);
        emit(8'h20, 6, -1);
        // R7 / R8: branch not taken, taken, taken across a page
        emit(8'h10, 2, -1);
        emit(8'h30, 3, -1);
        emit(8'hF0, 4, -1);
        // R9: unsupported opcode, then R10: early fetch inside a return
        emit(8'hEA, 4, -1);
        emit(8'h60, 3, -1);
        // R11: corrupted push of a break; R12: overrun of a call
        emit(8'h00, 7, 3);
        emit(8'h20, 8, -1);
        emit(8'h00, 2, -1);
        // Random mix
        for (int i = 0; i < 2500; i++) begin
            logic [7:0] op;
            int base, n, cor, r;
            r = $urandom % 6;
            case (r)
                0: op = 8'h00;
                1: op = 8'h40;
                2: op = 8'h60;
                3: op = 8'h20;
                4: op = {4'(($urandom % 8) * 2 + 1), 4'h0};
                default: op = pick_other();
            endcase
            base = script_of(op).len();
            if (base == 0) base = 1 + $urandom % 4;
            n = base;
            if (r == 4) n = 2 + $urandom % 3;
            else begin
                int v;
                v = $urandom % 10;
                if (v == 0) n = 1 + $urandom % base;
                else if (v == 1) n = base + 1 + $urandom % 2;
            end
            cor = -1;
            if (n > 1 && ($urandom % 12) == 0) cor = 1 + $urandom % (n - 1);
            emit(op, n, cor);
        end
        emit(8'h60, 6, -1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule